// File: doc/BRIEF.md
# Serial EEPROM Target Engine

This block is the two-wire bus target of a byte-wide nonvolatile memory. Its bus inputs pass through synchronizers, and it runs the protocol on the system clock. It detects Start and Stop conditions and accepts a device header whose upper four bits are the fixed pattern 1010, followed by three bits that must equal the strap inputs. The header's least significant bit selects the direction. A write header is followed by a two-byte word address, most significant byte first. Any data bytes after the address are stored, and the offset wraps inside the current page.

A header with the direction bit high starts a read at the internal address pointer. The read goes on byte after byte while the controller acknowledges, and the pointer wraps over the whole array. A random read is a write header carrying only the address, then a repeated Start and a read header. The block pulls SDA low through a single open-drain enable output. It uses that output for its own acknowledge bits and for the zero bits of read data.

The array holds 2^MEM_AW bytes in pages of 2^PAGE_AW bytes. Only the low MEM_AW bits of the 16-bit word address take effect. The system clock must run at least eight times faster than SCL.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A falling SDA while SCL is high is a Start, and a rising SDA while SCL is high is a Stop. A Start in any state drops any partly received byte and restarts header reception at its first bit. A Stop in any state releases SDA and returns to idle.
- R2: The block acknowledges a header only when header bits 7..4 are 1010 and bits 3..1 equal strap_i[2:0]. On any other header it does not pull SDA low for the rest of that transaction, including the bytes that follow.
- R3: Each header, address byte and write-data byte the block accepts is acknowledged by pulling SDA low for the whole ninth SCL clock.
- R4: The two bytes after a write header form the word address, most significant byte first. Only its low MEM_AW bits select the array location, so the high address bits have no effect.
- R5: Write data goes to consecutive locations. The low PAGE_AW bits of the address increment after each byte and wrap within the page, while the upper bits stay fixed.
- R6: A read with no preceding address returns the byte at the pointer. The pointer holds the last accessed location plus one: after writes this is the next page-wrapped location, and after reads it is the next array location.
- R7: While the controller acknowledges each read byte, the block sends the byte at the next address. The address wraps from the last array location to location 0.
- R8: A write header and two address bytes, followed by a repeated Start and a read header, return data starting at the newly loaded address.
- R9: After the controller answers a read byte with no acknowledge, the block stops pulling SDA low until the next Start.
- R10: The block changes its SDA drive only after an SCL falling edge, except that a Start or Stop releases it. Read data bits therefore stay stable while SCL is high.
- R11: After reset, SDA is released, the pointer is 0 and every array byte reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired level) |
| strap_i | input | 3 | Device select straps compared with header bits 3..1 |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The pointer wrap from the top of the array to location 0 is the hardest case to reach from the pins. Every location must first hold a distinct, known value, and a single read must then run without a break across the boundary. The bench therefore fills the whole array with an address-derived pattern, one full page per transaction. It then reads the entire array in one sequential read that starts in the middle. A second hard case is a Start or Stop that arrives partway through a byte. The bench drives the bus bit by bit, cuts a header off after a few bits, and then shows that the next full transaction returns the expected data.

// File: rtl/seep_pkg.sv
package seep_pkg;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_END,
        ST_RX_ACK,
        ST_TX,
        ST_TX_END,
        ST_TX_ACK
    } phase_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_AHI,
        K_ALO,
        K_WDAT
    } field_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    function automatic logic dev_match(input logic [6:0] hdr, input logic [2:0] strap);
        return hdr == {DEV_PREFIX, strap};
    endfunction

    function automatic field_e next_field(input field_e f);
        case (f)
            K_DEV:   return K_AHI;
            K_AHI:   return K_ALO;
            default: return K_WDAT;
        endcase
    endfunction

endpackage

// File: rtl/seep_line_sync.sv
module seep_line_sync
    import seep_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [1:0] raw;
    logic [1:0] cur;
    logic [1:0] prv;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) q <= '1;
            else     q <= {q[STAGES-2:0], raw[g]};
        end
        assign cur[g] = q[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prv <= '1;
        else     prv <= cur;
    end

    always_comb begin
        ev.rise  = cur[1] & ~prv[1];
        ev.fall  = ~cur[1] & prv[1];
        ev.start = cur[1] & prv[1] & prv[0] & ~cur[0];
        ev.stop  = cur[1] & prv[1] & ~prv[0] & cur[0];
        ev.sda   = cur[0];
    end

endmodule

// File: rtl/seep_mem.sv
module seep_mem #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/seep_ctrl.sv
module seep_ctrl
    import seep_pkg::*;
#(
    parameter int MEM_AW  = 8,
    parameter int PAGE_AW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [2:0]        strap,
    input  logic [7:0]        rdata,
    output logic [MEM_AW-1:0] ptr,
    output logic              we,
    output logic [MEM_AW-1:0] waddr,
    output logic [7:0]        wdata,
    output logic              sda_oe
);

    phase_e            phase;
    field_e            field;
    logic [2:0]        bitcnt;
    logic [6:0]        shreg;
    logic [MEM_AW-1:0] word_sr;
    logic              rw;
    logic              cont;

    logic [7:0]        rx_byte;
    logic              last_bit;
    logic [MEM_AW-1:0] ptr_in_page;

    assign rx_byte     = {shreg, ev.sda};
    assign last_bit    = (bitcnt == 3'd7);
    assign ptr_in_page = {ptr[MEM_AW-1:PAGE_AW], ptr[PAGE_AW-1:0] + PAGE_AW'(1)};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= ST_IDLE;
            field   <= K_DEV;
            bitcnt  <= '0;
            shreg   <= '0;
            word_sr <= '0;
            rw      <= 1'b0;
            cont    <= 1'b0;
            ptr     <= '0;
            we      <= 1'b0;
            waddr   <= '0;
            wdata   <= '0;
            sda_oe  <= 1'b0;
        end else begin
            we <= 1'b0;
            if (ev.start) begin
                phase  <= ST_RX;
                field  <= K_DEV;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                phase  <= ST_IDLE;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (phase)
                    ST_RX: begin
                        if (ev.rise) begin
                            shreg  <= rx_byte[6:0];
                            bitcnt <= bitcnt + 3'd1;
                            if (field == K_AHI || field == K_ALO)
                                word_sr <= {word_sr[MEM_AW-2:0], ev.sda};
                            if (last_bit) begin
                                phase <= ST_RX_END;
                                case (field)
                                    K_DEV: begin
                                        if (dev_match(rx_byte[7:1], strap)) rw <= rx_byte[0];
                                        else                                 phase <= ST_IDLE;
                                    end
                                    K_AHI: ;
                                    K_ALO: ptr <= {word_sr[MEM_AW-2:0], ev.sda};
                                    default: begin
                                        we    <= 1'b1;
                                        waddr <= ptr;
                                        wdata <= rx_byte;
                                        ptr   <= ptr_in_page;
                                    end
                                endcase
                            end
                        end
                    end
                    ST_RX_END: begin
                        if (ev.fall) begin
                            sda_oe <= 1'b1;
                            phase  <= ST_RX_ACK;
                        end
                    end
                    ST_RX_ACK: begin
                        if (ev.fall) begin
                            bitcnt <= '0;
                            if (field == K_DEV && rw) begin
                                shreg  <= rdata[6:0];
                                sda_oe <= ~rdata[7];
                                phase  <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                field  <= next_field(field);
                                phase  <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.rise) begin
                            bitcnt <= bitcnt + 3'd1;
                            if (last_bit) begin
                                ptr   <= ptr + MEM_AW'(1);
                                phase <= ST_TX_END;
                            end
                        end else if (ev.fall) begin
                            sda_oe <= ~shreg[6];
                            shreg  <= {shreg[5:0], 1'b0};
                        end
                    end
                    ST_TX_END: begin
                        if (ev.fall) begin
                            sda_oe <= 1'b0;
                            phase  <= ST_TX_ACK;
                        end
                    end
                    ST_TX_ACK: begin
                        if (ev.rise) begin
                            cont <= ~ev.sda;
                        end else if (ev.fall) begin
                            bitcnt <= '0;
                            if (cont) begin
                                shreg  <= rdata[6:0];
                                sda_oe <= ~rdata[7];
                                phase  <= ST_TX;
                            end else begin
                                phase  <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10: the drive only changes one cycle after a clock fall, Start or Stop
    assert_drive_on_fall_R10: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> ($past(ev.fall) || $past(ev.start) || $past(ev.stop)));

    // R10: pulling low never begins on anything but a clock fall
    assert_pull_after_fall_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(ev.fall));

    // R9: nothing is driven while idle
    assert_idle_released_R9: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_IDLE) |-> !sda_oe);

    // R1: a Start restarts header reception at its first bit
    assert_start_resync_R1: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (phase == ST_RX && bitcnt == 3'd0 && field == K_DEV));

    // R4: each stored byte produces a single write pulse
    assert_single_write_R4: assert property (@(posedge clk) disable iff (rst)
        we |=> !we);

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import seep_pkg::*;
#(
    parameter int MEM_AW      = 8,
    parameter int PAGE_AW     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_oe_o
);

    bus_ev_t           ev;
    logic [MEM_AW-1:0] ptr;
    logic              we;
    logic [MEM_AW-1:0] waddr;
    logic [7:0]        wdata;
    logic [7:0]        rdata;

    seep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    seep_ctrl #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .strap  (strap_i),
        .rdata  (rdata),
        .ptr    (ptr),
        .we     (we),
        .waddr  (waddr),
        .wdata  (wdata),
        .sda_oe (sda_oe_o)
    );

    seep_mem #(.AW(MEM_AW)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (ptr),
        .rdata (rdata)
    );

endmodule

// File: tb/i2c_eeprom_target_bench.sv
module i2c_eeprom_target_bench;

    localparam int MEM_AW  = 8;
    localparam int PAGE_AW = 4;
    localparam int DEPTH   = 1 << MEM_AW;
    localparam int PSIZE   = 1 << PAGE_AW;
    localparam int Q       = 4;
    localparam logic [2:0] MY_STRAP = 3'b101;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_ctl = 1'b1;
    logic [2:0] strap = MY_STRAP;
    logic       sda_oe;
    logic       sda_line;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] model [DEPTH];
    int         mptr = 0;

    always #10 clk = ~clk;

    assign sda_line = sda_ctl & ~sda_oe;

    i2c_eeprom_target #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW)) u_i2c_eeprom_target (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .strap_i  (strap),
        .sda_oe_o (sda_oe)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) ^ 8'h55);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_q;
        repeat (Q) @(negedge clk);
    endtask

    task automatic xfer_bit(input logic b, output logic s1, output logic s2);
        sda_ctl = b;
        wait_q();
        scl = 1'b1;
        wait_q();
        s1 = sda_line;
        wait_q();
        s2 = sda_line;
        scl = 1'b0;
        wait_q();
    endtask

    task automatic bus_start;
        sda_ctl = 1'b1;
        wait_q();
        scl = 1'b1;
        wait_q();
        sda_ctl = 1'b0;
        wait_q();
        scl = 1'b0;
        wait_q();
    endtask

    task automatic bus_stop;
        scl = 1'b0;
        sda_ctl = 1'b0;
        wait_q();
        scl = 1'b1;
        wait_q();
        sda_ctl = 1'b1;
        wait_q();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic a, b;
        for (int i = 7; i >= 0; i--) xfer_bit(d[i], a, b);
        xfer_bit(1'b1, a, b);
        ack = ~a & ~b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic give_ack);
        logic a, b;
        for (int i = 7; i >= 0; i--) begin
            xfer_bit(1'b1, a, b);
            d[i] = a;
            chk(a == b, "R10 read bit stable while SCL high", int'(b), int'(a));
        end
        xfer_bit(~give_ack, a, b);
    endtask

    task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
        logic ack;
        bus_start();
        send_byte({4'b1010, MY_STRAP, 1'b0}, ack);
        chk(ack, "R3 header ack", int'(ack), 1);
        send_byte(hi, ack);
        chk(ack, "R3 high address ack", int'(ack), 1);
        send_byte(lo, ack);
        chk(ack, "R3 low address ack", int'(ack), 1);
        mptr = int'(lo) & (DEPTH - 1);
    endtask

    task automatic read_run(input int n, input string tag);
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte({4'b1010, MY_STRAP, 1'b1}, ack);
        chk(ack, "R2 read header ack", int'(ack), 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(d, k != n - 1);
            chk(d == model[mptr], tag, int'(d), int'(model[mptr]));
            mptr = (mptr + 1) % DEPTH;
        end
    endtask

    initial begin
        logic ack, a, b;
        logic [7:0] d;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R11: released after reset, pointer 0, array cleared
        chk(sda_oe == 1'b0, "R11 SDA released after reset", int'(sda_oe), 0);
        read_run(1, "R11 byte at pointer 0 after reset");
        bus_stop();

        // R2: sweep all strap values against all headers with prefix 1010 or 1011
        for (int s = 0; s < 8; s++) begin
            strap = 3'(s);
            repeat (3) @(negedge clk);
            for (int h = 0; h < 16; h++) begin
                bit exp_ack;
                exp_ack = (h < 8) && (h == s);
                bus_start();
                send_byte({3'b101, 1'(h >> 3), 3'(h), 1'b0}, ack);
                chk(ack == exp_ack, "R2 header match", int'(ack), int'(exp_ack));
                bus_stop();
            end
        end
        strap = MY_STRAP;
        repeat (3) @(negedge clk);

        // R2: after a mismatch the following byte is not acknowledged either
        bus_start();
        send_byte({4'b1010, 3'b010, 1'b0}, ack);
        chk(!ack, "R2 foreign header ignored", int'(ack), 0);
        send_byte(8'h00, ack);
        chk(!ack, "R2 byte after foreign header ignored", int'(ack), 0);
        bus_stop();

        // R4 R5: page write of more than a page, high address byte ignored
        set_addr(8'h01, 8'h23);
        for (int i = 0; i < PSIZE + 4; i++) begin
            int wa;
            wa = (8'h23 & ~(PSIZE - 1)) | ((8'h23 + i) & (PSIZE - 1));
            send_byte(8'(8'h40 + i), ack);
            chk(ack, "R3 data ack", int'(ack), 1);
            model[wa] = 8'(8'h40 + i);
            mptr = (wa & ~(PSIZE - 1)) | ((wa + 1) & (PSIZE - 1));
        end
        bus_stop();

        // R6: current-address read after the page write
        read_run(1, "R6 current read after write");
        bus_stop();

        // R8 R5: random read over the written page
        set_addr(8'h00, 8'h20);
        read_run(PSIZE, "R8 R5 random then sequential read of page");
        bus_stop();

        // R4: fill the array one page per transaction
        for (int p = 0; p < DEPTH / PSIZE; p++) begin
            set_addr(8'h5A, 8'(p * PSIZE));
            for (int i = 0; i < PSIZE; i++) begin
                send_byte(pat(p * PSIZE + i), ack);
                chk(ack, "R4 fill data ack", int'(ack), 1);
                model[p * PSIZE + i] = pat(p * PSIZE + i);
            end
            bus_stop();
            mptr = p * PSIZE;
        end

        // R7: one sequential read of the whole array across the wrap
        set_addr(8'hFF, 8'h80);
        read_run(DEPTH, "R7 sequential read with array wrap");
        bus_stop();

        // R6: pointer continues after the long read
        read_run(1, "R6 current read after sequential read");
        bus_stop();

        // R1: Start in the middle of a header, then a full random read
        bus_start();
        for (int i = 0; i < 4; i++) xfer_bit(i[0], a, b);
        set_addr(8'h00, 8'h10);
        read_run(1, "R1 random read after Start abort");
        bus_stop();

        // R1: Stop in the middle of a byte; pointer unchanged
        bus_start();
        send_byte({4'b1010, MY_STRAP, 1'b0}, ack);
        chk(ack, "R3 header ack before Stop abort", int'(ack), 1);
        for (int i = 0; i < 3; i++) xfer_bit(1'b0, a, b);
        bus_stop();
        read_run(1, "R1 current read after Stop abort");

        // R9: after a NACK nothing is driven for the following clocks
        for (int i = 0; i < 9; i++) begin
            xfer_bit(1'b1, a, b);
            chk(a && b, "R9 SDA released after NACK", int'(a & b), 1);
        end
        bus_stop();
        read_run(1, "R9 current read after NACK and Stop");
        bus_stop();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL timeout (all requirements): actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule